// File: doc/BRIEF.md
# Eight-Pin Configurable GPIO Port

This block is a byte-wide general-purpose I/O port. Software reaches it through a small register bus with a select strobe, a write flag, an address and a byte of write data. Read data comes back combinationally from the same address. Three configuration registers set how each pin behaves: a latched output value, a direction bit and a mode bit. A fourth register holds interrupt-pending flags.

Each pin drives three pad controls: an output value, an output enable and a pull-up enable. Each pin also returns one input level from the pad. The mode bit changes meaning with direction. On an output pin it chooses between actively driving both levels and only pulling low. On an input pin it chooses between a floating input and a pulled-up input that can raise an interrupt. Pad inputs pass through a synchronizer chain before any use. A falling level on an armed input sets a pending flag that stays set until software clears it. The port's interrupt line is high whenever any flag is set.

Top module: `gpio_port8`

## Requirements
- R1: While reset is asserted and right after it is released, the value, direction, mode and pending registers all read 00h. pad_oe, pad_pu, pad_out and irq are all 0.
- R2: A register write happens on a rising clock edge with bus_sel=1 and bus_wr=1. Offset 1 holds the direction bits, where 1 means output and 0 means input. Each bit can be written and read back on its own.
- R3: A write to offset 0 is stored even when the pin is an input. The stored bit drives the pad as soon as the pin becomes a push-pull output.
- R4: A read at offset 0 returns, bit by bit, the stored value for output pins and the synchronized pad level for input pins.
- R5: An output pin with mode bit 1 (push-pull) has pad_oe=1 and pad_out equal to its stored bit.
- R6: An output pin with mode bit 0 (open-drain) has pad_out=0 and pad_oe equal to the inverse of its stored bit.
- R7: An input pin never drives, so pad_oe=0 and pad_out=0. Its pad_pu equals its mode bit. An output pin always has pad_pu=0.
- R8: A change on pad_in shows up in the offset-0 read of an input pin after the second rising edge, and not after the first.
- R9: A 1-to-0 change of an input pin with mode bit 1 sets its pending bit at offset 3 on the third rising edge after the pad changes. No pending bit is set by a rising change, by a floating input or by an output pin.
- R10: Pending bits stay set until a 1 is written to that bit position at offset 3. Writing 0 leaves them unchanged. irq is 1 exactly when some pending bit is 1.
- R11: Offsets 4 to 7 read 00h, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pad_in | input | 8 | Level seen at each pad |
| pad_out | output | 8 | Level driven to each pad |
| pad_oe | output | 8 | Per-pad output enable |
| pad_pu | output | 8 | Per-pad pull-up enable |
| irq | output | 1 | Port interrupt request |

## Verification
The hardest case to reach is the interrupt path, because it depends on three conditions lining up. The pin must be an input, its mode bit must be set, and its synchronized level must have been high before it falls. The stimulus first holds the pads high long enough to fill the synchronizer. It then clears any stale flags and drops a single pin. It samples the pending register one edge too early and again on the expected edge. Separate runs drop a floating pin and an output pin together, to show that neither sets a flag.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    OFS_VAL  = 2'd0,
    OFS_DIR  = 2'd1,
    OFS_MODE = 2'd2,
    OFS_PEND = 2'd3
  } gpio_ofs_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8,
  parameter int S = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg_q [S];
  logic [W-1:0] stg_d [S];

  always_comb begin
    stg_d[0] = din;
    for (int k = 1; k < S; k++) stg_d[k] = stg_q[k-1];
  end

  genvar g;
  generate
    for (g = 0; g < S; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= '0;
        else        stg_q[g] <= stg_d[g];
      end
    end
  endgenerate

  assign dout = stg_q[S-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  pin_lvl,
  input  logic [W-1:0]  pend,
  output logic [W-1:0]  val_q,
  output logic [W-1:0]  dir_q,
  output logic [W-1:0]  mode_q,
  output logic [W-1:0]  clr_mask,
  output logic [W-1:0]  rdata
);
  localparam logic [AW-1:0] A_VAL  = AW'(OFS_VAL);
  localparam logic [AW-1:0] A_DIR  = AW'(OFS_DIR);
  localparam logic [AW-1:0] A_MODE = AW'(OFS_MODE);
  localparam logic [AW-1:0] A_PEND = AW'(OFS_PEND);

  logic          wr_en;
  logic [W-1:0]  val_d, dir_d, mode_d;

  assign wr_en = sel & wr;

  always_comb begin
    val_d    = val_q;
    dir_d    = dir_q;
    mode_d   = mode_q;
    clr_mask = '0;
    if (wr_en) begin
      if (addr == A_VAL)  val_d    = wdata;
      if (addr == A_DIR)  dir_d    = wdata;
      if (addr == A_MODE) mode_d   = wdata;
      if (addr == A_PEND) clr_mask = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      dir_q  <= '0;
      mode_q <= '0;
    end else begin
      val_q  <= val_d;
      dir_q  <= dir_d;
      mode_q <= mode_d;
    end
  end

  always_comb begin
    if      (addr == A_VAL)  rdata = (dir_q & val_q) | (~dir_q & pin_lvl);
    else if (addr == A_DIR)  rdata = dir_q;
    else if (addr == A_MODE) rdata = mode_q;
    else if (addr == A_PEND) rdata = pend;
    else                     rdata = '0;
  end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] arm,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] pend_q,
  output logic         irq
);
  logic [W-1:0] prev_q;
  logic [W-1:0] fall;
  logic [W-1:0] pend_d;

  assign fall = prev_q & ~lvl & arm;

  always_comb begin
    pend_d = (pend_q & ~clr_mask) | fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= lvl;
      pend_q <= pend_d;
    end
  end

  assign irq = |pend_q;
endmodule

// File: rtl/gpio_pad_drv.sv
module gpio_pad_drv #(
  parameter int W = 8
) (
  input  logic [W-1:0] dir,
  input  logic [W-1:0] mode,
  input  logic [W-1:0] val,
  output logic [W-1:0] out,
  output logic [W-1:0] oe,
  output logic [W-1:0] pu
);
  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_pin
      always_comb begin
        out[g] = 1'b0;
        oe[g]  = 1'b0;
        pu[g]  = 1'b0;
        if (dir[g]) begin
          if (mode[g]) begin
            out[g] = val[g];
            oe[g]  = 1'b1;
          end else begin
            oe[g]  = ~val[g];
          end
        end else begin
          pu[g] = mode[g];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_port8.sv
module gpio_port8 #(
  parameter int W  = 8,
  parameter int AW = 3,
  parameter int S  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_oe,
  output logic [W-1:0]  pad_pu,
  output logic          irq
);
  logic [W-1:0] sync_lvl;
  logic [W-1:0] val_q, dir_q, mode_q;
  logic [W-1:0] clr_mask;
  logic [W-1:0] pend_q;
  logic [W-1:0] arm;

  assign arm = ~dir_q & mode_q;

  gpio_sync #(.W(W), .S(S)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(sync_lvl)
  );

  gpio_regs #(.W(W), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .pin_lvl(sync_lvl), .pend(pend_q), .val_q(val_q),
    .dir_q(dir_q), .mode_q(mode_q), .clr_mask(clr_mask), .rdata(bus_rdata)
  );

  gpio_edge_irq #(.W(W)) u_irq (
    .clk(clk), .rst_n(rst_n), .lvl(sync_lvl), .arm(arm),
    .clr_mask(clr_mask), .pend_q(pend_q), .irq(irq)
  );

  gpio_pad_drv #(.W(W)) u_drv (
    .dir(dir_q), .mode(mode_q), .val(val_q),
    .out(pad_out), .oe(pad_oe), .pu(pad_pu)
  );
endmodule

// File: rtl/gpio_port8_chk.sv
module gpio_port8_chk #(
  parameter int W  = 8,
  parameter int AW = 3,
  parameter int S  = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [W-1:0]  bus_wdata,
  input logic [W-1:0]  bus_rdata,
  input logic [W-1:0]  pad_in,
  input logic [W-1:0]  pad_out,
  input logic [W-1:0]  pad_oe,
  input logic [W-1:0]  pad_pu,
  input logic          irq,
  input logic [W-1:0]  val_q,
  input logic [W-1:0]  dir_q,
  input logic [W-1:0]  mode_q,
  input logic [W-1:0]  pend_q,
  input logic [W-1:0]  sync_lvl
);
  logic [1:0]   age_q;
  logic [W-1:0] w1c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  assign w1c = (bus_sel && bus_wr && bus_addr == AW'(3)) ? bus_wdata : '0;

  assert_pp_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((dir_q & mode_q & ~(pad_oe & ~(pad_out ^ val_q))) == '0));

  assert_od_never_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((dir_q & ~mode_q & pad_out) == '0));

  assert_pullup_not_driven_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pu & pad_oe) == '0));

  assert_rd_output_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == '0) |-> (((bus_rdata ^ val_q) & dir_q) == '0));

  assert_pend_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 2'd0) |-> ((($past(pend_q) & ~pend_q) & ~$past(w1c)) == '0));

  assert_pend_needs_arm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 2'd0) |-> (((pend_q & ~$past(pend_q)) & ~$past(~dir_q & mode_q)) == '0));

  assert_irq_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (pend_q != '0));

  generate
    if (S == 2) begin : g_two
      assert_sync_depth_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (sync_lvl == $past(pad_in, 2)));
    end
  endgenerate
endmodule

bind gpio_port8 gpio_port8_chk #(.W(W), .AW(AW), .S(S)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
  .irq(irq), .val_q(val_q), .dir_q(dir_q), .mode_q(mode_q),
  .pend_q(pend_q), .sync_lvl(sync_lvl)
);

// File: tb/sim_gpio_port8.sv
module sim_gpio_port8;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_sel, bus_wr;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic [7:0] pad_in, pad_out, pad_oe, pad_pu;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  gpio_port8 u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .irq(irq)
  );

  always #5 clk = ~clk;

  // {dir, mode, value, pad, exp_out, exp_oe, exp_pu, exp_rd0}
  localparam logic [63:0] VEC [6] = '{
    64'hFF_FF_A5_00_A5_FF_00_A5,
    64'hFF_00_A5_00_00_5A_00_A5,
    64'h00_FF_A5_3C_00_00_FF_3C,
    64'h00_00_FF_C3_00_00_00_C3,
    64'hF0_CC_5A_96_40_E0_0C_56,
    64'h0F_33_0F_FF_03_03_30_FF
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; pad_in = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 oe in reset", pad_oe, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 pad_pu", pad_pu, 8'h00);
    chk("R1 pad_out", pad_out, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rd(3'd1, r); chk("R1 dir", r, 8'h00);
    rd(3'd2, r); chk("R1 mode", r, 8'h00);
    rd(3'd3, r); chk("R1 pend", r, 8'h00);

    // table walk: R2 R4 R5 R6 R7
    foreach (VEC[i]) begin
      @(negedge clk);
      pad_in = VEC[i][39:32];
      wr(3'd1, VEC[i][63:56]);
      wr(3'd2, VEC[i][55:48]);
      wr(3'd0, VEC[i][47:40]);
      @(negedge clk);
      rd(3'd1, r); chk("R2 dir readback", r, VEC[i][63:56]);
      chk("R5/R6/R7 pad_out", pad_out, VEC[i][31:24]);
      chk("R5/R6/R7 pad_oe", pad_oe, VEC[i][23:16]);
      chk("R7 pad_pu", pad_pu, VEC[i][15:8]);
      rd(3'd0, r); chk("R4 value read", r, VEC[i][7:0]);
    end

    // R3: value stored while input, driven when switched to output
    wr(3'd1, 8'h00); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    @(negedge clk); pad_in = 8'h00;
    wr(3'd0, 8'h3C);
    @(negedge clk);
    rd(3'd0, r); chk("R3 input shows pad", r, 8'h00);
    chk("R3 no drive as input", pad_oe, 8'h00);
    wr(3'd1, 8'hFF);
    chk("R3 drives stored value", pad_out, 8'h3C);
    rd(3'd0, r); chk("R3 readback stored", r, 8'h3C);

    // R8: synchronizer depth
    wr(3'd1, 8'h00); wr(3'd2, 8'h00);
    @(negedge clk); pad_in = 8'h5A;
    @(negedge clk); rd(3'd0, r); chk("R8 not after first edge", r, 8'h00);
    @(negedge clk); rd(3'd0, r); chk("R8 after second edge", r, 8'h5A);

    // R9/R10: falling edge interrupt
    wr(3'd2, 8'h01);
    @(negedge clk); pad_in = 8'hFF;
    repeat (3) @(negedge clk);
    wr(3'd3, 8'hFF);
    rd(3'd3, r); chk("R10 cleared start", r, 8'h00);
    pad_in = 8'hFE;
    @(negedge clk); @(negedge clk);
    rd(3'd3, r); chk("R9 not yet after two edges", r, 8'h00);
    chk("R10 irq low early", {7'd0, irq}, 8'h00);
    @(negedge clk);
    rd(3'd3, r); chk("R9 set on third edge", r, 8'h01);
    chk("R10 irq high", {7'd0, irq}, 8'h01);
    pad_in = 8'hFF;
    repeat (4) @(negedge clk);
    rd(3'd3, r); chk("R10 sticky after rise", r, 8'h01);
    wr(3'd3, 8'hFE);
    rd(3'd3, r); chk("R10 write zero keeps", r, 8'h01);
    wr(3'd3, 8'h01);
    rd(3'd3, r); chk("R10 write one clears", r, 8'h00);
    chk("R10 irq low after clear", {7'd0, irq}, 8'h00);

    // R9: floating input (bit1) and output (bit2) falls set nothing
    wr(3'd1, 8'h04); wr(3'd2, 8'h05);
    repeat (3) @(negedge clk);
    pad_in = 8'hF9;
    repeat (4) @(negedge clk);
    rd(3'd3, r); chk("R9 floating/output no pend", r, 8'h00);
    chk("R9 irq stays low", {7'd0, irq}, 8'h00);

    // R11: unmapped offsets
    wr(3'd4, 8'hAA); wr(3'd7, 8'h55);
    rd(3'd1, r); chk("R11 dir untouched", r, 8'h04);
    rd(3'd2, r); chk("R11 mode untouched", r, 8'h05);
    rd(3'd4, r); chk("R11 read 4", r, 8'h00);
    rd(3'd7, r); chk("R11 read 7", r, 8'h00);

    // R1: reset again mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    rd(3'd1, r); chk("R1 dir after re-reset", r, 8'h00);
    chk("R1 oe after re-reset", pad_oe, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule